// File: doc/BRIEF.md
# Third-Order Sigma-Delta Bitstream Modulator

This block turns a stream of 10-bit signed samples into a one-bit oversampled stream. It runs on the bit clock. A new sample arrives, with a valid strobe, once every ten bit clocks. The block holds that sample (zero-order hold) and feeds it into a loop of three cascaded integrators. The sign of the last integrator is the output bit. That same bit steers the feedback multiplexer of every stage, so over any long stretch the density of ones follows the input level.

Each integrator adds exactly one registered operand to its own state per clock. The two terms that a stage needs are the stage's input (the held sample, or the previous integrator) and its feedback correction. These two terms are summed one cycle early into a pair register. This keeps the path between registers to a single two-input add at the cost of one extra cycle of loop delay per stage. The feedback gains are chosen for the loop that includes this delay. The integrators wrap in two's complement. They do not saturate.

Top module: `sdm3_modulator`

## Requirements
- R1: A synchronous reset clears the held sample, the three pair registers and the three integrators to zero, so `bit_out` is 0 while reset is applied and in the cycle after the edge where it is released.
- R2: `smp_data` is read as a 10-bit two's-complement value and sign-extended to 32 bits. It is captured only on a clock edge where `smp_valid` is 1, and then held. Values on `smp_data` in cycles without the strobe have no effect on the output stream.
- R3: `bit_out` is the sign bit (bit 31) of the third integrator. A 1 stands for the negative output level −FS and a 0 for +FS, where FS = 512.
- R4: Each stage has a feedback multiplexer steered by `bit_out`. When the bit is 1 it selects +k·FS, and when the bit is 0 it selects −k·FS. The gains are k = 1, 48 and 768 for stages 1, 2 and 3.
- R5: On each edge, pair register i loads (stage-i input + feedback), and integrator i adds the pair value registered on the previous edge. After reset the output therefore stays 0 for the first edge and rises to 1 on the second edge after release.
- R6: For a constant input x with |x| ≤ 180, the number of ones in any 1024-bit window after settling is 512 − x ± 24. This equals 1024·(FS − x)/(2·FS).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe, one cycle in ten |
| smp_data | input | 10 | Signed input sample |
| bit_out | output | 1 | Oversampled one-bit stream (1 = −FS level) |

## Verification
The bench targets the first two edges after reset. A design with the wrong number of pipeline registers would raise the output on the first edge or on the third edge instead of the second. Negative DC levels are tested because a missing sign extension would turn a small negative sample into a large positive one and push the ones density far out of tolerance. A feedback multiplexer with the wrong polarity would drive the loop into runaway and fail every density window. The bench also runs the same sample sequence twice, once with garbage on the data bus between strobes, and compares the two streams bit for bit. An ungated capture register would make the streams differ.

// File: rtl/sdm3_pkg.sv
package sdm3_pkg;

   // number of cascaded integrator stages
   localparam int unsigned SDM_ORDER = 3;

   // meaning of the output bit as a feedback level
   typedef enum logic {
      LVL_POS = 1'b0,
      LVL_NEG = 1'b1
   } sdm_level_e;

endpackage

// File: rtl/sdm3_hold.sv
module sdm3_hold #(
   parameter int unsigned IN_W  = 10,
   parameter int unsigned ACC_W = 32
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    smp_valid,
   input  logic [IN_W-1:0]         smp_data,
   output logic signed [ACC_W-1:0] held_q
);

   localparam int unsigned EXT_W = ACC_W - IN_W;

   always_ff @(posedge clk) begin
      if (rst)
         held_q <= '0;
      else if (smp_valid)
         held_q <= {{EXT_W{smp_data[IN_W-1]}}, smp_data};
   end

   // the held value may only move on a strobe
   assert_hold_stable_R2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(smp_valid)) |-> $stable(held_q));

endmodule

// File: rtl/sdm3_pair.sv
module sdm3_pair
   import sdm3_pkg::*;
#(
   parameter int unsigned ACC_W  = 32,
   parameter longint      FB_MAG = 512
) (
   input  logic                    clk,
   input  logic                    rst,
   input  sdm_level_e              level,
   input  logic signed [ACC_W-1:0] operand,
   output logic signed [ACC_W-1:0] pair_q
);

   localparam logic signed [ACC_W-1:0] FB = ACC_W'(FB_MAG);

   logic signed [ACC_W-1:0] fb_sel;

   // negative output level -> push the stage up, otherwise pull it down
   assign fb_sel = (level == LVL_NEG) ? FB : -FB;

   always_ff @(posedge clk) begin
      if (rst)
         pair_q <= '0;
      else
         pair_q <= operand + fb_sel;
   end

   // feedback direction: a negative output level raises the pair above its operand
   assert_fb_dir_R4: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(level) == LVL_NEG) |-> (pair_q > $past(operand)));

endmodule

// File: rtl/sdm3_acc.sv
module sdm3_acc #(
   parameter int unsigned ACC_W    = 32,
   parameter longint      STEP_MAX = 0
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic signed [ACC_W-1:0] pair_d,
   output logic signed [ACC_W-1:0] acc_q
);

   always_ff @(posedge clk) begin
      if (rst)
         acc_q <= '0;
      else
         acc_q <= acc_q + pair_d;
   end

   if (STEP_MAX > 0) begin : g_step_chk
      localparam logic signed [ACC_W-1:0] LIM = ACC_W'(STEP_MAX);
      // a held 10-bit sample plus one FS correction bounds each step
      assert_step_bound_R2: assert property (@(posedge clk) disable iff (rst)
         !$past(rst) |-> (($signed(acc_q - $past(acc_q)) <= LIM) &&
                          ($signed(acc_q - $past(acc_q)) >= -LIM)));
   end

endmodule

// File: rtl/sdm3_modulator.sv
module sdm3_modulator
   import sdm3_pkg::*;
#(
   parameter int unsigned IN_W  = 10,
   parameter int unsigned ACC_W = 32,
   parameter longint      GAIN1 = 1,
   parameter longint      GAIN2 = 48,
   parameter longint      GAIN3 = 768
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            smp_valid,
   input  logic [IN_W-1:0] smp_data,
   output logic            bit_out
);

   localparam longint FS = longint'(1) <<< (IN_W - 1);

   function automatic longint stage_gain(int idx);
      case (idx)
         0:       return GAIN1;
         1:       return GAIN2;
         default: return GAIN3;
      endcase
   endfunction

   // elaboration-time parameter checks
   if (IN_W < 2 || IN_W >= ACC_W) begin : g_bad_width
      $error("sdm3_modulator: IN_W must be at least 2 and below ACC_W");
   end
   if (ACC_W > 62) begin : g_bad_acc
      $error("sdm3_modulator: ACC_W above 62 is not supported");
   end
   if ((FS * GAIN3 * 64) >= (longint'(1) <<< (ACC_W - 1))) begin : g_no_room
      $error("sdm3_modulator: ACC_W leaves too little headroom for the last stage");
   end

   logic signed [ACC_W-1:0] held_s;
   logic signed [ACC_W-1:0] opnd_v [SDM_ORDER];
   logic signed [ACC_W-1:0] pair_v [SDM_ORDER];
   logic signed [ACC_W-1:0] acc_v  [SDM_ORDER];
   sdm_level_e              lvl;

   sdm3_hold #(.IN_W(IN_W), .ACC_W(ACC_W)) u_hold (
      .clk       (clk),
      .rst       (rst),
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .held_q    (held_s)
   );

   for (genvar i = 0; i < SDM_ORDER; i++) begin : g_stage
      localparam longint MAG  = FS * stage_gain(i);
      localparam longint STEP = (i == 0) ? 2 * FS : 0;

      if (i == 0) begin : g_first
         assign opnd_v[i] = held_s;
      end else begin : g_chain
         assign opnd_v[i] = acc_v[i-1];
      end

      sdm3_pair #(.ACC_W(ACC_W), .FB_MAG(MAG)) u_pair (
         .clk     (clk),
         .rst     (rst),
         .level   (lvl),
         .operand (opnd_v[i]),
         .pair_q  (pair_v[i])
      );

      sdm3_acc #(.ACC_W(ACC_W), .STEP_MAX(STEP)) u_acc (
         .clk    (clk),
         .rst    (rst),
         .pair_d (pair_v[i]),
         .acc_q  (acc_v[i])
      );
   end

   assign lvl     = sdm_level_e'(acc_v[SDM_ORDER-1][ACC_W-1]);
   assign bit_out = acc_v[SDM_ORDER-1][ACC_W-1];

   // reset leaves the output at the positive level
   assert_rst_out_R1: assert property (@(posedge clk)
      $past(rst) |-> !bit_out);

endmodule

// File: tb/tb_sdm3_modulator.sv
`timescale 1ns/1ps
module tb_sdm3_modulator;

   localparam int IN_W = 10;
   localparam int FS   = 512;
   localparam int WIN  = 1024;
   localparam int TOL  = 24;
   localparam int SLEN = 600;

   typedef struct {
      int exp_ones;
      bit live;
      int xval;
   } win_t;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            smp_valid = 1'b0;
   logic [IN_W-1:0] smp_data = '0;
   logic            bit_out;

   int   n_total = 0;
   int   n_bad   = 0;
   win_t sb_q[$];
   bit   mon_en = 1'b0;
   int   mon_cnt = 0;
   int   mon_ones = 0;
   bit   str_a [SLEN];
   bit   str_b [SLEN];

   sdm3_modulator dut (
      .clk       (clk),
      .rst       (rst),
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .bit_out   (bit_out)
   );

   always #5 clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_total++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // reset, then R1 and R5 checks on the first edges after release
   task automatic reset_seq(input int x);
      rst = 1'b1;
      smp_valid = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      rst = 1'b0;
      smp_valid = 1'b1;
      smp_data = IN_W'(x);
      @(negedge clk);
      check(bit_out == 1'b0, "R1 output in reset state", int'(bit_out), 0);
      @(posedge clk);
      #1;
      smp_valid = 1'b0;
      @(negedge clk);
      check(bit_out == 1'b0, "R1 R5 first edge after release", int'(bit_out), 0);
      @(negedge clk);
      check(bit_out == 1'b1, "R5 R4 second edge after release", int'(bit_out), 1);
   endtask

   // drive one cycle of the 10:1 sample pattern
   task automatic drive_cycle(input int k, input int x, input bit garble);
      @(posedge clk);
      #1;
      smp_valid = (k % 10 == 0);
      if (k % 10 == 0 || !garble)
         smp_data = IN_W'(x);
      else
         smp_data = IN_W'($urandom);
   endtask

   // driver: expected windows go into the scoreboard, first window only settles
   task automatic drive_dc(input int x, input int nwin, input bit garble);
      for (int w = 0; w < nwin; w++)
         sb_q.push_back('{(WIN * (FS - x)) / (2 * FS), (w > 0), x});
      for (int k = 0; k < nwin * WIN; k++) begin
         drive_cycle(k, x, garble);
         mon_en = 1'b1;
      end
      @(negedge clk);
      #1;
      mon_en = 1'b0;
   endtask

   // monitor: count ones per window and compare with the scoreboard
   always @(negedge clk) begin
      if (mon_en) begin
         mon_ones += int'(bit_out);
         mon_cnt++;
         if (mon_cnt == WIN) begin
            win_t it;
            it = sb_q.pop_front();
            if (it.live) begin
               n_total++;
               if (mon_ones > it.exp_ones + TOL || mon_ones < it.exp_ones - TOL) begin
                  n_bad++;
                  $display("FAIL R6 R3 x=%0d actual=%0d expected=%0d", it.xval, mon_ones, it.exp_ones);
               end
            end
            mon_cnt = 0;
            mon_ones = 0;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_total++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end

   initial begin
      reset_seq(0);

      // R6 R3: density of ones tracks DC levels of both signs (R2 sign extension)
      drive_dc(0, 2, 1'b0);
      drive_dc(90, 2, 1'b0);
      drive_dc(-60, 2, 1'b0);
      drive_dc(180, 2, 1'b0);
      drive_dc(-180, 2, 1'b0);
      drive_dc(37, 2, 1'b0);
      // R2: garbage between strobes must not disturb tracking
      drive_dc(-120, 2, 1'b1);

      // R2: identical streams with clean and garbled bus between strobes
      reset_seq(123);
      for (int k = 0; k < SLEN; k++) begin
         drive_cycle(k, 123, 1'b0);
         @(negedge clk);
         str_a[k] = bit_out;
      end
      reset_seq(123);
      for (int k = 0; k < SLEN; k++) begin
         drive_cycle(k, 123, 1'b1);
         @(negedge clk);
         str_b[k] = bit_out;
      end
      begin
         int mism = 0;
         for (int k = 0; k < SLEN; k++)
            if (str_a[k] != str_b[k]) mism++;
         check(mism == 0, "R2 stream unchanged by unstrobed data", mism, 0);
      end

      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end

endmodule